// File: doc/BRIEF.md
# Triggered PWM Register Synchronizer

This block decides when the shadow copies of a PWM timer's settings become the live settings. Software writes new values for the period limit, the counter start value, the channel compare levels, a per-channel output mask and a per-pair output swap word into buffer inputs. The live copies change only on a synchronization event. A software request bit and a hardware trigger pulse can each raise that event, and a separate enable for each source selects which register groups respond. The counter itself lives elsewhere. This block tells it when to restart, through a reload strobe, and reads the loading-point indication that the counter raises when it reaches its period limit.

The limit, start and compare values form one group that always changes as a whole. A four-state machine governs that group. ST_IDLE waits for an event. An event whose source has counter restart enabled takes the RELOAD transition into ST_RELOAD, which lasts one cycle and raises both the commit strobe and the counter reload. An event without restart takes the DEFER transition into ST_HOLD. ST_HOLD takes the LOADPT transition into ST_LOAD at the next loading point. If software withdraws a software-only request while in ST_HOLD, the CANCEL transition returns it to ST_IDLE. A restart event seen in ST_HOLD takes the PREEMPT transition into ST_RELOAD. ST_RELOAD and ST_LOAD fall back to ST_IDLE through the DONE transition, or they start again if a new event arrives in the same cycle.

The mask word and the swap word each commit one cycle after a trigger and take no notice of the loading point. An output stage applies both words to the raw complementary pair signals: the swap is applied first and the mask after it.

Top module: `pwm_sync_commit`

## Requirements
- R1: `cur_mod`, `cur_start` and every field of `cur_cmp` take their buffer values in the same cycle, and that is the cycle in which `commit_buf` is 1. In any cycle with `commit_buf` at 0, none of them changes.
- R2: With `en_sw_buf`=1 and `rst_on_sw`=1, a `sw_req_set` pulse in cycle k makes `sw_req` 1 in cycle k+1. In cycle k+2, `commit_buf` and `cnt_reload` are 1, the new values are live and `sw_req` is 0.
- R3: With `en_sw_buf`=1 and `rst_on_sw`=0, the request stays pending and `sw_req` stays 1 until `at_modulo` is 1 in some cycle m. In cycle m+1, `commit_buf` is 1, `cnt_reload` is 0 and `sw_req` is 0.
- R4: If a pending software-only request is cleared through `sw_req_clr` before the loading point, no commit follows, including at later loading points.
- R5: `hw_trig` acts only while `arm` is 1. With `trig_mode`=0, a trigger in cycle h with restart enabled commits in cycle h+1, `arm` reads 0 from cycle h+1, and later triggers have no effect until `arm_set` is pulsed.
- R6: With `trig_mode`=1, `arm` stays 1 until `arm_clr` is pulsed, and every trigger commits.
- R7: With `en_hw_buf`=1 and `rst_on_hw`=0, an armed trigger commits in the cycle after the next cycle that has `at_modulo`=1, with `cnt_reload` at 0.
- R8: The mask word commits when `grp_mask` is 1 and the event's source enable (`en_sw_mask` or `en_hw_mask`) is 1. The swap word commits under the same rule using `grp_inv`, `en_sw_inv` and `en_hw_inv`. Each commit takes effect one cycle after the trigger (for a software request, one cycle after `sw_req` first reads 1) with `commit_mask` or `commit_inv` high, whatever the state of `at_modulo`.
- R9: When bit c of `cur_mask` is 1, `pwm_out[c]` equals `init_lvl[c]`.
- R10: For pair p, when `cur_inv[p]` is 1, channel 2p shows `pwm_raw[2p+1]` and channel 2p+1 shows `pwm_raw[2p]`. When it is 0, both pass straight through. The mask is applied after the swap.
- R11: A software request seen while `en_sw_buf`, `grp_mask` and `grp_inv` are all 0 changes no live value, and `sw_req` reads 0 one cycle after it first reads 1.
- R12: A software request and an armed hardware trigger detected in the same cycle form a single event, which produces exactly one commit. If either source has restart enabled, the commit is immediate and `sw_req` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req_set | input | 1 | Software writes 1 to the request bit |
| sw_req_clr | input | 1 | Software writes 0 to the request bit |
| arm_set | input | 1 | Software sets the hardware arm bit |
| arm_clr | input | 1 | Software clears the hardware arm bit |
| trig_mode | input | 1 | 1: arm is sticky, 0: arm self-clears after a trigger |
| hw_trig | input | 1 | Hardware trigger pulse |
| at_modulo | input | 1 | Counter is at its loading point |
| en_sw_buf | input | 1 | Software path enable for limit/start/compare group |
| en_hw_buf | input | 1 | Hardware path enable for limit/start/compare group |
| rst_on_sw | input | 1 | Software event restarts the counter and commits at once |
| rst_on_hw | input | 1 | Hardware event restarts the counter and commits at once |
| grp_mask | input | 1 | Mask word synchronization enable |
| en_sw_mask | input | 1 | Mask word software path enable |
| en_hw_mask | input | 1 | Mask word hardware path enable |
| grp_inv | input | 1 | Swap word synchronization enable |
| en_sw_inv | input | 1 | Swap word software path enable |
| en_hw_inv | input | 1 | Swap word hardware path enable |
| buf_mod | input | CW | Buffered period limit |
| buf_start | input | CW | Buffered counter start value |
| buf_cmp | input | NCH*CW | Buffered compare levels, channel c at bits c*CW |
| buf_mask | input | NCH | Buffered output mask, bit c for channel c |
| buf_inv | input | NPAIR | Buffered pair swap word, bit p for pair p |
| pwm_raw | input | NCH | Raw channel waveforms |
| init_lvl | input | NCH | Safe level per channel |
| cur_mod | output | CW | Live period limit |
| cur_start | output | CW | Live start value |
| cur_cmp | output | NCH*CW | Live compare levels |
| cur_mask | output | NCH | Live output mask |
| cur_inv | output | NPAIR | Live swap word |
| commit_buf | output | 1 | Limit/start/compare group committed this cycle |
| cnt_reload | output | 1 | Counter restart request |
| commit_mask | output | 1 | Mask word committed this cycle |
| commit_inv | output | 1 | Swap word committed this cycle |
| sw_req | output | 1 | Software request bit |
| arm | output | 1 | Hardware arm bit |
| pwm_out | output | NCH | Masked and swapped channel outputs |

## Verification
A state machine that stays in ST_HOLD after it should have left shows up at the ports as a `commit_buf` pulse one cycle after a later loading point, or as `sw_req` still at 1 when R3 expects it to have dropped. A wrong pending-source flag shows up as a commit after a cancelled request at the very next `at_modulo`. An arm bit that clears at the wrong time shows up as a missing or extra commit on the following hardware pulse, one cycle after that pulse. A wrong live mask or swap word is visible on `pwm_out` in the same cycle.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RELOAD = 2'd2,
        ST_LOAD   = 2'd3
    } commit_st_e;
endpackage

// File: rtl/pwm_sync_arm.sv
// Request bit and hardware arm bit, plus event qualification.
module pwm_sync_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req_set,
    input  logic sw_req_clr,
    input  logic sw_clear,
    input  logic arm_set,
    input  logic arm_clr,
    input  logic trig_mode,
    input  logic hw_trig,
    output logic sw_req,
    output logic sw_fresh,
    output logic arm,
    output logic hw_ev
);
    logic sw_req_q;
    logic sw_prev_q;
    logic arm_q;

    assign sw_req   = sw_req_q;
    assign arm      = arm_q;
    assign sw_fresh = sw_req_q & ~sw_prev_q;
    assign hw_ev    = hw_trig & arm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_req_q  <= 1'b0;
            sw_prev_q <= 1'b0;
            arm_q     <= 1'b0;
        end else begin
            sw_prev_q <= sw_req_q;
            if (sw_req_clr || sw_clear) begin
                sw_req_q <= 1'b0;
            end else if (sw_req_set) begin
                sw_req_q <= 1'b1;
            end
            if (arm_set) begin
                arm_q <= 1'b1;
            end else if (arm_clr) begin
                arm_q <= 1'b0;
            end else if (hw_ev && !trig_mode) begin
                arm_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwm_buf_commit_fsm.sv
// Commit controller for the limit / start / compare group.
module pwm_buf_commit_fsm
    import pwm_sync_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_hit,
    input  logic              hw_hit,
    input  logic              rst_on_sw,
    input  logic              rst_on_hw,
    input  logic              sw_req,
    input  logic              at_modulo,
    input  logic [CW-1:0]     buf_mod,
    input  logic [CW-1:0]     buf_start,
    input  logic [NCH*CW-1:0] buf_cmp,
    output logic [CW-1:0]     cur_mod,
    output logic [CW-1:0]     cur_start,
    output logic [NCH*CW-1:0] cur_cmp,
    output logic              commit_buf,
    output logic              cnt_reload,
    output logic              enter_commit,
    output logic              sw_keep
);
    commit_st_e st_q, st_n;
    logic       pend_hw_q, pend_hw_n;
    logic       imm;
    logic       any_hit;

    assign imm     = (sw_hit && rst_on_sw) || (hw_hit && rst_on_hw);
    assign any_hit = sw_hit || hw_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            pend_hw_q <= 1'b0;
        end else begin
            st_q      <= st_n;
            pend_hw_q <= pend_hw_n;
        end
    end

    // transitions
    always_comb begin
        st_n      = ST_IDLE;
        pend_hw_n = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_RELOAD, ST_LOAD: begin
                if (imm) begin
                    st_n = ST_RELOAD;                 // RELOAD
                end else if (any_hit) begin
                    st_n      = ST_HOLD;              // DEFER
                    pend_hw_n = hw_hit;
                end else begin
                    st_n = ST_IDLE;                   // DONE
                end
            end
            ST_HOLD: begin
                if (imm) begin
                    st_n = ST_RELOAD;                 // PREEMPT
                end else if (at_modulo && (pend_hw_q || sw_req)) begin
                    st_n = ST_LOAD;                   // LOADPT
                end else if (pend_hw_q || hw_hit || sw_req) begin
                    st_n      = ST_HOLD;
                    pend_hw_n = pend_hw_q || hw_hit;
                end else begin
                    st_n = ST_IDLE;                   // CANCEL
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        commit_buf   = (st_q == ST_RELOAD) || (st_q == ST_LOAD);
        cnt_reload   = (st_q == ST_RELOAD);
        enter_commit = (st_n == ST_RELOAD) || (st_n == ST_LOAD);
        sw_keep      = (st_n == ST_HOLD) && sw_hit;
    end

    // live copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mod   <= '0;
            cur_start <= '0;
            cur_cmp   <= '0;
        end else if (enter_commit) begin
            cur_mod   <= buf_mod;
            cur_start <= buf_start;
            cur_cmp   <= buf_cmp;
        end
    end
endmodule

// File: rtl/pwm_word_commit.sv
// One-cycle commit of an independently enabled word.
module pwm_word_commit #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grp_en,
    input  logic         sw_en,
    input  logic         hw_en,
    input  logic         sw_ev,
    input  logic         hw_ev,
    input  logic [W-1:0] nxt_val,
    output logic [W-1:0] cur_val,
    output logic         commit
);
    logic fire;

    assign fire = grp_en && ((sw_en && sw_ev) || (hw_en && hw_ev));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_val <= '0;
            commit  <= 1'b0;
        end else begin
            commit <= fire;
            if (fire) begin
                cur_val <= nxt_val;
            end
        end
    end
endmodule

// File: rtl/pwm_pair_stage.sv
// Swap then mask on each complementary pair.
module pwm_pair_stage #(
    parameter  int NPAIR = 2,
    localparam int NCH   = 2 * NPAIR
) (
    input  logic [NCH-1:0]   raw,
    input  logic [NCH-1:0]   lvl,
    input  logic [NCH-1:0]   mask,
    input  logic [NPAIR-1:0] inv,
    output logic [NCH-1:0]   out
);
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic even_sw;
        logic odd_sw;
        assign even_sw = inv[p] ? raw[2*p+1] : raw[2*p];
        assign odd_sw  = inv[p] ? raw[2*p]   : raw[2*p+1];
        assign out[2*p]   = mask[2*p]   ? lvl[2*p]   : even_sw;
        assign out[2*p+1] = mask[2*p+1] ? lvl[2*p+1] : odd_sw;
    end
endmodule

// File: rtl/pwm_sync_commit.sv
module pwm_sync_commit #(
    parameter  int CW    = 16,
    parameter  int NPAIR = 2,
    localparam int NCH   = 2 * NPAIR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req_set,
    input  logic              sw_req_clr,
    input  logic              arm_set,
    input  logic              arm_clr,
    input  logic              trig_mode,
    input  logic              hw_trig,
    input  logic              at_modulo,
    input  logic              en_sw_buf,
    input  logic              en_hw_buf,
    input  logic              rst_on_sw,
    input  logic              rst_on_hw,
    input  logic              grp_mask,
    input  logic              en_sw_mask,
    input  logic              en_hw_mask,
    input  logic              grp_inv,
    input  logic              en_sw_inv,
    input  logic              en_hw_inv,
    input  logic [CW-1:0]     buf_mod,
    input  logic [CW-1:0]     buf_start,
    input  logic [NCH*CW-1:0] buf_cmp,
    input  logic [NCH-1:0]    buf_mask,
    input  logic [NPAIR-1:0]  buf_inv,
    input  logic [NCH-1:0]    pwm_raw,
    input  logic [NCH-1:0]    init_lvl,
    output logic [CW-1:0]     cur_mod,
    output logic [CW-1:0]     cur_start,
    output logic [NCH*CW-1:0] cur_cmp,
    output logic [NCH-1:0]    cur_mask,
    output logic [NPAIR-1:0]  cur_inv,
    output logic              commit_buf,
    output logic              cnt_reload,
    output logic              commit_mask,
    output logic              commit_inv,
    output logic              sw_req,
    output logic              arm,
    output logic [NCH-1:0]    pwm_out
);
    logic sw_fresh;
    logic hw_ev;
    logic sw_hit;
    logic hw_hit;
    logic enter_commit;
    logic sw_keep;
    logic sw_clear;

    assign sw_hit   = sw_fresh && en_sw_buf;
    assign hw_hit   = hw_ev && en_hw_buf;
    assign sw_clear = enter_commit || (sw_fresh && !sw_keep);

    pwm_sync_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_req_set (sw_req_set),
        .sw_req_clr (sw_req_clr),
        .sw_clear   (sw_clear),
        .arm_set    (arm_set),
        .arm_clr    (arm_clr),
        .trig_mode  (trig_mode),
        .hw_trig    (hw_trig),
        .sw_req     (sw_req),
        .sw_fresh   (sw_fresh),
        .arm        (arm),
        .hw_ev      (hw_ev)
    );

    pwm_buf_commit_fsm #(.CW(CW), .NCH(NCH)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_hit       (sw_hit),
        .hw_hit       (hw_hit),
        .rst_on_sw    (rst_on_sw),
        .rst_on_hw    (rst_on_hw),
        .sw_req       (sw_req),
        .at_modulo    (at_modulo),
        .buf_mod      (buf_mod),
        .buf_start    (buf_start),
        .buf_cmp      (buf_cmp),
        .cur_mod      (cur_mod),
        .cur_start    (cur_start),
        .cur_cmp      (cur_cmp),
        .commit_buf   (commit_buf),
        .cnt_reload   (cnt_reload),
        .enter_commit (enter_commit),
        .sw_keep      (sw_keep)
    );

    pwm_word_commit #(.W(NCH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_en  (grp_mask),
        .sw_en   (en_sw_mask),
        .hw_en   (en_hw_mask),
        .sw_ev   (sw_fresh),
        .hw_ev   (hw_ev),
        .nxt_val (buf_mask),
        .cur_val (cur_mask),
        .commit  (commit_mask)
    );

    pwm_word_commit #(.W(NPAIR)) u_inv (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_en  (grp_inv),
        .sw_en   (en_sw_inv),
        .hw_en   (en_hw_inv),
        .sw_ev   (sw_fresh),
        .hw_ev   (hw_ev),
        .nxt_val (buf_inv),
        .cur_val (cur_inv),
        .commit  (commit_inv)
    );

    pwm_pair_stage #(.NPAIR(NPAIR)) u_stage (
        .raw  (pwm_raw),
        .lvl  (init_lvl),
        .mask (cur_mask),
        .inv  (cur_inv),
        .out  (pwm_out)
    );
endmodule

// File: rtl/pwm_sync_commit_chk.sv
module pwm_sync_commit_chk #(
    parameter  int CW    = 16,
    parameter  int NPAIR = 2,
    localparam int NCH   = 2 * NPAIR
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_req,
    input logic              arm,
    input logic              hw_trig,
    input logic              arm_set,
    input logic              arm_clr,
    input logic              trig_mode,
    input logic              at_modulo,
    input logic              en_sw_buf,
    input logic              rst_on_sw,
    input logic              commit_buf,
    input logic              cnt_reload,
    input logic              commit_mask,
    input logic              commit_inv,
    input logic [CW-1:0]     cur_mod,
    input logic [CW-1:0]     cur_start,
    input logic [NCH*CW-1:0] cur_cmp,
    input logic [NCH-1:0]    cur_mask,
    input logic [NPAIR-1:0]  cur_inv,
    input logic [NCH-1:0]    init_lvl,
    input logic [NCH-1:0]    pwm_out
);
    a_r1_group_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_buf |-> ($stable(cur_mod) && $stable(cur_start) && $stable(cur_cmp)));

    a_r2_reload_has_commit: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reload |-> commit_buf);

    a_r2_sw_restart_path: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !$past(sw_req) && en_sw_buf && rst_on_sw) |=> (cnt_reload && !sw_req));

    a_r3_load_after_point: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_buf && !cnt_reload) |-> $past(at_modulo));

    a_r5_arm_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_trig && arm && !trig_mode && !arm_set) |=> !arm);

    a_r6_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && trig_mode && !arm_clr) |=> arm);

    a_r8_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_mask |-> $stable(cur_mask));

    a_r8_inv_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_inv |-> $stable(cur_inv));

    for (genvar c = 0; c < NCH; c++) begin : g_mask_chk
        a_r9_mask_level: assert property (@(posedge clk) disable iff (!rst_n)
            cur_mask[c] |-> (pwm_out[c] == init_lvl[c]));
    end
endmodule

bind pwm_sync_commit pwm_sync_commit_chk #(.CW(CW), .NPAIR(NPAIR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_req      (sw_req),
    .arm         (arm),
    .hw_trig     (hw_trig),
    .arm_set     (arm_set),
    .arm_clr     (arm_clr),
    .trig_mode   (trig_mode),
    .at_modulo   (at_modulo),
    .en_sw_buf   (en_sw_buf),
    .rst_on_sw   (rst_on_sw),
    .commit_buf  (commit_buf),
    .cnt_reload  (cnt_reload),
    .commit_mask (commit_mask),
    .commit_inv  (commit_inv),
    .cur_mod     (cur_mod),
    .cur_start   (cur_start),
    .cur_cmp     (cur_cmp),
    .cur_mask    (cur_mask),
    .cur_inv     (cur_inv),
    .init_lvl    (init_lvl),
    .pwm_out     (pwm_out)
);

// File: tb/pwm_sync_commit_bench.sv
module pwm_sync_commit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW    = 16;
    localparam int NPAIR = 2;
    localparam int NCH   = 2 * NPAIR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_req_set = 0, sw_req_clr = 0, arm_set = 0, arm_clr = 0;
    logic trig_mode = 0, hw_trig = 0, at_modulo = 0;
    logic en_sw_buf = 0, en_hw_buf = 0, rst_on_sw = 0, rst_on_hw = 0;
    logic grp_mask = 0, en_sw_mask = 0, en_hw_mask = 0;
    logic grp_inv = 0, en_sw_inv = 0, en_hw_inv = 0;
    logic [CW-1:0]     buf_mod = '0, buf_start = '0;
    logic [NCH*CW-1:0] buf_cmp = '0;
    logic [NCH-1:0]    buf_mask = '0;
    logic [NPAIR-1:0]  buf_inv = '0;
    logic [NCH-1:0]    pwm_raw = '0, init_lvl = '0;
    logic [CW-1:0]     cur_mod, cur_start;
    logic [NCH*CW-1:0] cur_cmp;
    logic [NCH-1:0]    cur_mask;
    logic [NPAIR-1:0]  cur_inv;
    logic commit_buf, cnt_reload, commit_mask, commit_inv, sw_req, arm;
    logic [NCH-1:0]    pwm_out;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [CW-1:0]     old_mod;
    logic [NCH*CW-1:0] old_cmp;
    logic [NCH-1:0]    old_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_sync_commit #(.CW(CW), .NPAIR(NPAIR)) u_pwm_sync_commit (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic new_bufs();
        buf_mod   = CW'($urandom);
        buf_start = CW'($urandom);
        buf_cmp   = {$urandom, $urandom};
    endtask

    task automatic keep_old();
        old_mod = cur_mod;
        old_cmp = cur_cmp;
    endtask

    function automatic logic [NCH-1:0] ref_out(input logic [NCH-1:0] raw,
            input logic [NCH-1:0] lvl, input logic [NCH-1:0] m, input logic [NPAIR-1:0] v);
        logic [NCH-1:0] r;
        for (int p = 0; p < NPAIR; p++) begin
            r[2*p]   = v[p] ? raw[2*p+1] : raw[2*p];
            r[2*p+1] = v[p] ? raw[2*p]   : raw[2*p+1];
        end
        for (int c = 0; c < NCH; c++) if (m[c]) r[c] = lvl[c];
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        pwm_raw = 4'b1010;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        chk("reset commit_buf", commit_buf, 0);
        chk("reset cnt_reload", cnt_reload, 0);
        chk("reset sw_req", sw_req, 0);
        chk("reset arm", arm, 0);
        chk("reset cur_mod", cur_mod, 0);
        chk("reset cur_mask", cur_mask, 0);
        chk("reset R10 passthrough", pwm_out, pwm_raw);

        // R2 software with restart, R1 group commit
        en_sw_buf = 1; rst_on_sw = 1; new_bufs();
        sw_req_set = 1; tick(); sw_req_set = 0;
        chk("R2 sw_req up", sw_req, 1);
        chk("R2 no early commit", commit_buf, 0);
        tick();
        chk("R2 commit", commit_buf, 1);
        chk("R2 reload", cnt_reload, 1);
        chk("R2 sw_req cleared", sw_req, 0);
        chk("R1 mod", cur_mod, buf_mod);
        chk("R1 start", cur_start, buf_start);
        chk("R1 cmp", cur_cmp, buf_cmp);
        keep_old(); new_bufs();
        tick();
        chk("R2 single pulse", commit_buf, 0);
        repeat (3) tick();
        chk("R1 mod held", cur_mod, old_mod);
        chk("R1 cmp held", cur_cmp, old_cmp);

        // R3 software deferred to loading point
        rst_on_sw = 0; new_bufs();
        sw_req_set = 1; tick(); sw_req_set = 0;
        repeat (3) tick();
        chk("R3 waits", commit_buf, 0);
        chk("R3 sw_req pending", sw_req, 1);
        at_modulo = 1; tick(); at_modulo = 0;
        chk("R3 commit", commit_buf, 1);
        chk("R3 no reload", cnt_reload, 0);
        chk("R3 sw_req cleared", sw_req, 0);
        chk("R3 mod", cur_mod, buf_mod);
        chk("R3 start", cur_start, buf_start);

        // R4 cancellation
        keep_old(); new_bufs();
        sw_req_set = 1; tick(); sw_req_set = 0;
        tick();
        sw_req_clr = 1; tick(); sw_req_clr = 0;
        at_modulo = 1; tick(); at_modulo = 0;
        chk("R4 no commit", commit_buf, 0);
        at_modulo = 1; tick(); at_modulo = 0;
        tick();
        chk("R4 no late commit", commit_buf, 0);
        chk("R4 mod unchanged", cur_mod, old_mod);
        chk("R4 sw_req", sw_req, 0);

        // R11 software with enables off
        en_sw_buf = 0; keep_old(); new_bufs();
        sw_req_set = 1; tick(); sw_req_set = 0;
        chk("R11 sw_req seen", sw_req, 1);
        tick();
        chk("R11 sw_req self-clear", sw_req, 0);
        chk("R11 no commit", commit_buf, 0);
        at_modulo = 1; tick(); at_modulo = 0; tick();
        chk("R11 mod unchanged", cur_mod, old_mod);
        chk("R11 mask unchanged", cur_mask, 0);

        // R5 one-shot hardware arming
        en_hw_buf = 1; rst_on_hw = 1; trig_mode = 0; keep_old(); new_bufs();
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R5 unarmed no commit", commit_buf, 0);
        chk("R5 unarmed mod", cur_mod, old_mod);
        arm_set = 1; tick(); arm_set = 0;
        chk("R5 armed", arm, 1);
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R5 commit", commit_buf, 1);
        chk("R5 reload", cnt_reload, 1);
        chk("R5 arm cleared", arm, 0);
        chk("R5 mod", cur_mod, buf_mod);
        keep_old(); new_bufs();
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R5 second trigger ignored", commit_buf, 0);
        tick();
        chk("R5 mod held", cur_mod, old_mod);

        // R6 sticky arming
        trig_mode = 1; arm_set = 1; tick(); arm_set = 0;
        for (int i = 0; i < 3; i++) begin
            new_bufs();
            hw_trig = 1; tick(); hw_trig = 0;
            chk("R6 each trigger commits", commit_buf, 1);
            chk("R6 mod", cur_mod, buf_mod);
            chk("R6 arm stays", arm, 1);
            tick();
        end
        arm_clr = 1; tick(); arm_clr = 0;
        chk("R6 arm cleared by sw", arm, 0);
        keep_old(); new_bufs();
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R6 disarmed no commit", commit_buf, 0);
        chk("R6 mod held", cur_mod, old_mod);

        // R7 hardware deferred to loading point
        rst_on_hw = 0; arm_set = 1; tick(); arm_set = 0;
        keep_old(); new_bufs();
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R7 waits", commit_buf, 0);
        tick(); tick();
        chk("R7 still waits", commit_buf, 0);
        chk("R7 mod held", cur_mod, old_mod);
        at_modulo = 1; tick(); at_modulo = 0;
        chk("R7 commit", commit_buf, 1);
        chk("R7 no reload", cnt_reload, 0);
        chk("R7 cmp", cur_cmp, buf_cmp);
        tick();
        chk("R7 single pulse", commit_buf, 0);

        // R8 mask and swap words
        en_hw_buf = 0; en_sw_buf = 0;
        grp_mask = 1; en_hw_mask = 1; en_sw_mask = 0;
        grp_inv = 1; en_sw_inv = 1; en_hw_inv = 0;
        buf_mask = 4'b0110; buf_inv = 2'b10;
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R8 mask commit", commit_mask, 1);
        chk("R8 mask value", cur_mask, 4'b0110);
        chk("R8 inv not on hw", commit_inv, 0);
        chk("R8 buf group untouched", commit_buf, 0);
        sw_req_set = 1; tick(); sw_req_set = 0;
        chk("R8 inv not yet", commit_inv, 0);
        tick();
        chk("R8 inv commit", commit_inv, 1);
        chk("R8 inv value", cur_inv, 2'b10);
        chk("R8 mask not on sw", commit_mask, 0);
        grp_mask = 0; old_mask = cur_mask; buf_mask = 4'b1001;
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R8 group off no commit", commit_mask, 0);
        chk("R8 mask held", cur_mask, old_mask);

        // R9 R10 random output stage
        grp_mask = 1; en_hw_mask = 1; en_hw_inv = 1; en_sw_inv = 0;
        for (int i = 0; i < 40; i++) begin
            buf_mask = NCH'($urandom);
            buf_inv  = NPAIR'($urandom);
            if (i == 0) begin buf_mask = '1; buf_inv = '1; end
            if (i == 1) begin buf_mask = '0; buf_inv = '1; end
            if (i == 2) begin buf_mask = '0; buf_inv = '0; end
            hw_trig = 1; tick(); hw_trig = 0;
            chk("R8 random mask commit", cur_mask, buf_mask);
            for (int j = 0; j < 4; j++) begin
                pwm_raw  = NCH'($urandom);
                init_lvl = NCH'($urandom);
                #1;
                chk("R9 R10 output stage", pwm_out,
                    ref_out(pwm_raw, init_lvl, buf_mask, buf_inv));
                tick();
            end
        end
        grp_mask = 0; grp_inv = 0;

        // R12 simultaneous software and hardware
        en_sw_buf = 1; rst_on_sw = 1; en_hw_buf = 1; rst_on_hw = 1;
        trig_mode = 1; arm_set = 1; tick(); arm_set = 0;
        new_bufs();
        sw_req_set = 1; tick(); sw_req_set = 0;
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R12 one commit", commit_buf, 1);
        chk("R12 reload", cnt_reload, 1);
        chk("R12 mod", cur_mod, buf_mod);
        tick();
        chk("R12 no second commit", commit_buf, 0);
        tick();
        chk("R12 still one", commit_buf, 0);
        rst_on_sw = 0; new_bufs();
        sw_req_set = 1; tick(); sw_req_set = 0;
        hw_trig = 1; tick(); hw_trig = 0;
        chk("R12 mixed immediate", cnt_reload, 1);
        chk("R12 mixed sw_req cleared", sw_req, 0);
        at_modulo = 1; tick(); at_modulo = 0;
        chk("R12 mixed no extra", commit_buf, 0);
        tick();
        chk("R12 mixed no late", commit_buf, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule